// File: doc/BRIEF.md
# Serial EEPROM Command Slave

This block is the slave end of a three-wire serial memory link, run from a fast system clock. It holds sixteen 16-bit words in flip-flops. The chip-select, serial-clock, data and program-enable pins are asynchronous to the system clock, so each goes through a synchronizer. After the synchronizer the block looks for rising serial-clock edges. It waits for a start bit, then collects a two-bit opcode and a four-bit word address, most significant bit first. Opcode `10` is a read and `01` is a single-word write. Opcode `00` is an extended command, and bits [3:2] of its address field select the action: `11` sets the write-enable latch, `00` clears it, `01` writes one word to all locations, and `10` is ignored. Opcode `11` is ignored.

A read starts with one zero bit, followed by the addressed word. If the master keeps clocking, the next word follows with no gap. A write starts on the falling edge of chip select, which must come after the last data bit and before any further clock. A counter then stands in for the self-timed programming time. The new data is committed when the count ends. An external protection unit supplies two inputs:

- a per-address "protected" flag, looked up from the address the block presents;
- a global "cleared" flag, which permits write-all.

Top module: `ser_eeprom`

## Requirements
- R1: After synchronous reset, `sdo` is 0, the write-enable latch is clear and every word reads as 0x0000.
- R2: A read frame (start 1, opcode 10, 4-bit address) produces one 0 bit and then the 16 bits of the addressed word, MSB first. Each bit changes only after a rising `sclk` edge.
- R3: If `sclk` keeps running after the 16th data bit, the address increments (15 wraps to 0) and the next word follows at once, with no zero bit between words.
- R4: A write or write-all changes memory only while the write-enable latch is set. Extended address 11xx sets the latch and 00xx clears it.
- R5: Reads return stored data whether the write-enable latch is set or clear.
- R6: A write frame (opcode 01) carries 16 data bits, MSB first, after the address. `csel` falling before the next rising `sclk` edge starts programming. A further `sclk` rise before `csel` falls cancels the write.
- R7: `prog_en` must be 1 on every sampled bit, from the start bit through the last data bit, or the write or write-all is dropped. Its level after the last data bit has no effect.
- R8: Once programming has started, raising `csel` shows `sdo` = 0 while busy and 1 after PROG_CYCLES system clocks. The memory update lands at the end of that window.
- R9: Write-all (extended address 01xx, then 16 data bits) stores the word in all sixteen locations, but only if `prot_clear` is 1 when `csel` falls. Otherwise nothing is changed and no programming cycle starts.
- R10: `chk_addr` presents the frame address. A single-word write whose address has `prot_hit` = 1 still runs a full busy cycle, but leaves the word unchanged.
- R11: While programming is busy, start bits are ignored, so any frame sent during that time has no effect.
- R12: Zeros clocked in before the start bit are ignored. Dropping `csel` part-way through a frame aborts it without any change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; bits sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| prog_en | input | 1 | Program-enable pin, required high while a write is shifted in |
| prot_hit | input | 1 | From the protection unit: the address on `chk_addr` is protected |
| prot_clear | input | 1 | From the protection unit: protection is in the cleared state |
| sdo | output | 1 | Serial data out, or ready/busy status |
| chk_addr | output | 4 | Current frame address, sent to the protection unit |

## Verification
Most internal faults show up only at `sdo`. A bad header shift or address counter shows up as a wrong word within the read frame that follows. A stray dummy bit or a lost increment shifts the second word of a sequential read by one bit. A wrong enable latch, program-enable flag or write-all gate shows up only when a read-back made after the full PROG_CYCLES window returns the old data. A timer of the wrong length shows up as a ready flag that rises early or late during status polling.

// File: rtl/ser_eeprom_pkg.sv
package ser_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_READ,
    ST_DATA,
    ST_WAITCS,
    ST_HOLD
  } se_state_t;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_EXT   = 2'b00;

  localparam logic [1:0] EXT_WEN   = 2'b11;
  localparam logic [1:0] EXT_WDS   = 2'b00;
  localparam logic [1:0] EXT_WALL  = 2'b01;

endpackage

// File: rtl/se_front.sv
module se_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic csel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic pen_i,
  output logic csel_s,
  output logic sdi_s,
  output logic pen_s,
  output logic sclk_rise,
  output logic csel_fall
);
  localparam int NIN = 4;

  logic [NIN-1:0] raw;
  logic [NIN-1:0] synced;
  logic           sclk_prev;
  logic           csel_prev;

  assign raw = {pen_i, sdi_i, sclk_i, csel_i};

  for (genvar i = 0; i < NIN; i++) begin : g_sync
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], raw[i]};
    end
    assign synced[i] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      csel_prev <= 1'b0;
    end else begin
      sclk_prev <= synced[1];
      csel_prev <= synced[0];
    end
  end

  assign csel_s    = synced[0];
  assign sdi_s     = synced[2];
  assign pen_s     = synced[3];
  assign sclk_rise = synced[1] & ~sclk_prev;
  assign csel_fall = ~synced[0] & csel_prev;
endmodule

// File: rtl/se_timer.sv
module se_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = busy && (cnt_q == '0);
endmodule

// File: rtl/se_regfile.sv
module se_regfile #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          we_all,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH*DW-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)
        word_q <= '0;
      else if (we_all || (we && waddr == AW'(g)))
        word_q <= wdata;
    end
    assign flat[g*DW +: DW] = word_q;
  end

  assign rdata = flat[raddr*DW +: DW];
endmodule

// File: rtl/se_ctrl.sv
module se_ctrl
  import ser_eeprom_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csel_s,
  input  logic          sdi_s,
  input  logic          pen_s,
  input  logic          sclk_rise,
  input  logic          csel_fall,
  input  logic          busy,
  input  logic          done,
  input  logic          prot_hit,
  input  logic          prot_clear,
  input  logic [DW-1:0] rdata,
  output logic          sdo,
  output logic [AW-1:0] addr,
  output logic          prog_start,
  output logic          mem_we,
  output logic          mem_we_all,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          wen
);
  localparam int HW   = AW + 2;
  localparam int MAXB = (DW > HW) ? DW : HW;
  localparam int CW   = $clog2(MAXB) + 1;

  se_state_t     state;
  logic [HW-2:0] hdr_sr;
  logic [HW-1:0] hdr_full;
  logic [1:0]    opc;
  logic [AW-1:0] a_next;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] sr_q;
  logic          pe_ok;
  logic          is_all;
  logic          load_pend;
  logic          stat_flag;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;
  logic          pend_all;
  logic          pend_ok;

  assign hdr_full = {hdr_sr, sdi_s};
  assign opc      = hdr_full[HW-1:HW-2];
  assign a_next   = hdr_full[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      hdr_sr     <= '0;
      bitcnt     <= '0;
      addr       <= '0;
      sr_q       <= '0;
      pe_ok      <= 1'b0;
      is_all     <= 1'b0;
      load_pend  <= 1'b0;
      stat_flag  <= 1'b0;
      wen        <= 1'b0;
      sdo        <= 1'b0;
      prog_start <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
      pend_all   <= 1'b0;
      pend_ok    <= 1'b0;
    end else begin
      prog_start <= 1'b0;
      if (!csel_s) begin
        sdo       <= 1'b0;
        load_pend <= 1'b0;
        state     <= ST_IDLE;
        if (csel_fall && state == ST_WAITCS && wen && pe_ok && !busy &&
            (!is_all || prot_clear)) begin
          prog_start <= 1'b1;
          stat_flag  <= 1'b1;
          pend_addr  <= addr;
          pend_data  <= sr_q;
          pend_all   <= is_all;
          pend_ok    <= is_all || !prot_hit;
        end
      end else begin
        if (load_pend) begin
          sr_q      <= rdata;
          load_pend <= 1'b0;
        end
        case (state)
          ST_IDLE: begin
            if (sclk_rise && sdi_s && !busy) begin
              state     <= ST_HDR;
              bitcnt    <= '0;
              pe_ok     <= pen_s;
              stat_flag <= 1'b0;
              sdo       <= 1'b0;
            end else if (stat_flag) begin
              sdo <= !busy;
            end
          end
          ST_HDR: begin
            if (sclk_rise) begin
              pe_ok  <= pe_ok & pen_s;
              hdr_sr <= hdr_full[HW-2:0];
              if (bitcnt == CW'(HW - 1)) begin
                bitcnt <= '0;
                addr   <= a_next;
                if (opc == OPC_READ) begin
                  state     <= ST_READ;
                  sdo       <= 1'b0;
                  load_pend <= 1'b1;
                end else if (opc == OPC_WRITE) begin
                  state  <= ST_DATA;
                  is_all <= 1'b0;
                end else if (opc == OPC_EXT) begin
                  case (a_next[AW-1:AW-2])
                    EXT_WEN:  begin wen <= 1'b1; state <= ST_HOLD; end
                    EXT_WDS:  begin wen <= 1'b0; state <= ST_HOLD; end
                    EXT_WALL: begin is_all <= 1'b1; state <= ST_DATA; end
                    default:  state <= ST_HOLD;
                  endcase
                end else begin
                  state <= ST_HOLD;
                end
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_READ: begin
            if (sclk_rise && !load_pend) begin
              sdo <= sr_q[DW-1];
              if (bitcnt == CW'(DW - 1)) begin
                bitcnt    <= '0;
                addr      <= addr + 1'b1;
                load_pend <= 1'b1;
              end else begin
                sr_q   <= {sr_q[DW-2:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_DATA: begin
            if (sclk_rise) begin
              pe_ok <= pe_ok & pen_s;
              sr_q  <= {sr_q[DW-2:0], sdi_s};
              if (bitcnt == CW'(DW - 1)) state <= ST_WAITCS;
              else                       bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_WAITCS: begin
            if (sclk_rise) state <= ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  assign mem_we     = done && pend_ok && !pend_all;
  assign mem_we_all = done && pend_ok && pend_all;
  assign waddr      = pend_addr;
  assign wdata      = pend_data;
endmodule

// File: rtl/ser_eeprom.sv
module ser_eeprom #(
  parameter int AW          = 4,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csel,
  input  logic          sclk,
  input  logic          sdi,
  input  logic          prog_en,
  input  logic          prot_hit,
  input  logic          prot_clear,
  output logic          sdo,
  output logic [AW-1:0] chk_addr
);
  logic          csel_s, sdi_s, pen_s, sclk_rise, csel_fall;
  logic          busy, done, prog_start;
  logic          mem_we, mem_we_all, wen;
  logic [AW-1:0] waddr, addr;
  logic [DW-1:0] wdata, rdata;

  se_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .csel_i(csel), .sclk_i(sclk), .sdi_i(sdi),
    .pen_i(prog_en), .csel_s(csel_s), .sdi_s(sdi_s), .pen_s(pen_s),
    .sclk_rise(sclk_rise), .csel_fall(csel_fall)
  );

  se_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .csel_s(csel_s), .sdi_s(sdi_s), .pen_s(pen_s),
    .sclk_rise(sclk_rise), .csel_fall(csel_fall), .busy(busy), .done(done),
    .prot_hit(prot_hit), .prot_clear(prot_clear), .rdata(rdata), .sdo(sdo),
    .addr(addr), .prog_start(prog_start), .mem_we(mem_we),
    .mem_we_all(mem_we_all), .waddr(waddr), .wdata(wdata), .wen(wen)
  );

  se_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(prog_start), .busy(busy), .done(done)
  );

  se_regfile #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .we_all(mem_we_all), .waddr(waddr),
    .wdata(wdata), .raddr(addr), .rdata(rdata)
  );

  assign chk_addr = addr;
endmodule

// File: rtl/ser_eeprom_chk.sv
module ser_eeprom_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic clk,
  input logic rst,
  input logic sdo,
  input logic csel_s,
  input logic busy,
  input logic prog_start,
  input logic mem_we,
  input logic mem_we_all,
  input logic wen
);
  localparam int KW = $clog2(PROG_CYCLES + 2) + 1;

  logic [KW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)             busy_cnt <= '0;
    else if (prog_start) busy_cnt <= '0;
    else if (busy)       busy_cnt <= busy_cnt + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!sdo && !wen));

  p_write_needs_wen_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_we_all) |-> wen);

  p_busy_len_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == KW'(PROG_CYCLES)));

  p_commit_last_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_we_all) |=> !busy);

  p_one_port_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_we_all}));

  p_start_idle_r11: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> !busy);

  p_start_runs_r11: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> busy);

  p_cs_low_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !csel_s |=> !sdo);
endmodule

bind ser_eeprom ser_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .sdo(sdo), .csel_s(csel_s), .busy(busy),
  .prog_start(prog_start), .mem_we(mem_we), .mem_we_all(mem_we_all),
  .wen(wen)
);

// File: tb/sim_ser_eeprom.sv
`timescale 1ns/1ps
module sim_ser_eeprom;
  localparam int PROG = 200;
  localparam int H    = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csel = 1'b0, sclk = 1'b0, sdi = 1'b0, prog_en = 1'b1;
  logic       prot_clear = 1'b0;
  logic [4:0] prot_bound = 5'd16;
  logic       prot_hit;
  logic       sdo;
  logic [3:0] chk_addr;

  logic [15:0] exp_mem [16];
  int tests = 0, fails = 0;
  int bitno = 0, pe_drop = -1;
  bit finished = 1'b0;

  // {addr, data}
  localparam logic [19:0] VEC [6] = '{
    20'hEA5C3, 20'hFF00F, 20'h08001, 20'h71234, 20'h35A5A, 20'hB8E17
  };

  assign prot_hit = {1'b0, chk_addr} >= prot_bound;

  always #2.5 clk = ~clk;

  ser_eeprom #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst(rst), .csel(csel), .sclk(sclk), .sdi(sdi),
    .prog_en(prog_en), .prot_hit(prot_hit), .prot_clear(prot_clear),
    .sdo(sdo), .chk_addr(chk_addr)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    sclk = 1'b0; sdi = b;
    prog_en = (bitno == pe_drop) ? 1'b0 : 1'b1;
    bitno++;
    tick(H); sclk = 1'b1; tick(H);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [3:0] a, input int zeros);
    csel = 1'b1; tick(2);
    for (int z = 0; z < zeros; z++) bit_out(1'b0);
    bitno = 0;
    bit_out(1'b1); bit_out(op[1]); bit_out(op[0]);
    for (int i = 3; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic send_data(input logic [15:0] d, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) bit_out(d[i]);
  endtask

  task automatic end_cmd;
    sclk = 1'b0; tick(H); csel = 1'b0; tick(H);
  endtask

  task automatic finish_write(input bit cycle, input string tag);
    sclk = 1'b0; tick(H); csel = 1'b0; tick(H);
    csel = 1'b1; tick(H);
    if (cycle) check({tag, " busy"}, {15'd0, sdo}, 16'd0);
    tick(PROG + 20);
    check({tag, " ready"}, {15'd0, sdo}, {15'd0, cycle});
    csel = 1'b0; tick(H);
  endtask

  task automatic read_check(input logic [3:0] a, input int n, input string tag, input int zeros);
    send_hdr(2'b10, a, zeros);
    check({tag, " dummy"}, {15'd0, sdo}, 16'd0);
    for (int w = 0; w < n; w++) begin
      logic [15:0] word;
      for (int b = 15; b >= 0; b--) begin
        bit_out(1'b0);
        word[b] = sdo;
      end
      check(tag, word, exp_mem[(int'(a) + w) % 16]);
    end
    end_cmd;
  endtask

  task automatic set_wen(input bit on);
    send_hdr(2'b00, on ? 4'b1100 : 4'b0000, 0);
    end_cmd;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary;
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_mem[i] = 16'h0000;
    tick(5); rst = 1'b0; tick(3);

    // R1: reset state
    check("R1 sdo after reset", {15'd0, sdo}, 16'd0);
    read_check(4'd5, 1, "R1 R5 word zero after reset", 0);

    // R4: write while disabled has no effect
    send_hdr(2'b01, 4'd3, 0); send_data(16'hBEEF, 16);
    finish_write(1'b0, "R4 disabled write");
    read_check(4'd3, 1, "R4 disabled write unchanged", 0);

    // R6 R2 R8: table of writes, each read back
    set_wen(1'b1);
    for (int v = 0; v < 6; v++) begin
      send_hdr(2'b01, VEC[v][19:16], 0); send_data(VEC[v][15:0], 16);
      finish_write(1'b1, "R8 status");
      exp_mem[VEC[v][19:16]] = VEC[v][15:0];
      read_check(VEC[v][19:16], 1, "R6 R2 table readback", 0);
    end

    // R3: sequential read with wrap 14,15,0
    read_check(4'd14, 3, "R3 sequential wrap", 0);

    // R7: prog_en low during a data bit drops the write
    pe_drop = 12;
    send_hdr(2'b01, 4'd7, 0); send_data(16'h0F0F, 16);
    pe_drop = -1;
    finish_write(1'b0, "R7 pe low mid-frame");
    read_check(4'd7, 1, "R7 pe low unchanged", 0);

    // R7: prog_en low after last data bit is ignored
    send_hdr(2'b01, 4'd7, 0); send_data(16'hC3C3, 16);
    prog_en = 1'b0;
    finish_write(1'b1, "R7 pe after load");
    prog_en = 1'b1;
    exp_mem[7] = 16'hC3C3;
    read_check(4'd7, 1, "R7 pe after load written", 0);

    // R6: extra clock before csel falls cancels
    send_hdr(2'b01, 4'd7, 0); send_data(16'h1111, 16); bit_out(1'b0);
    finish_write(1'b0, "R6 extra clock");
    read_check(4'd7, 1, "R6 cancelled write unchanged", 0);

    // R12: abort part-way, then leading zeros before a read
    send_hdr(2'b01, 4'd0, 0); send_data(16'h7777, 8);
    end_cmd;
    read_check(4'd0, 1, "R12 abort and leading zeros", 2);

    // R10: protected write runs a cycle but keeps data
    prot_bound = 5'd8;
    send_hdr(2'b01, 4'd9, 0); send_data(16'h2222, 16);
    finish_write(1'b1, "R10 protected cycle");
    check("R10 chk_addr", {12'd0, chk_addr}, 16'd9);
    read_check(4'd9, 1, "R10 protected unchanged", 0);
    send_hdr(2'b01, 4'd6, 0); send_data(16'h6666, 16);
    finish_write(1'b1, "R10 unprotected cycle");
    exp_mem[6] = 16'h6666;
    read_check(4'd6, 1, "R10 unprotected written", 0);

    // R11: frame sent while busy is ignored
    send_hdr(2'b01, 4'd2, 0); send_data(16'h4242, 16);
    sclk = 1'b0; tick(H); csel = 1'b0; tick(H);
    send_hdr(2'b00, 4'b0000, 0);
    end_cmd;
    tick(PROG + 20);
    exp_mem[2] = 16'h4242;
    read_check(4'd2, 1, "R11 busy write done", 0);
    send_hdr(2'b01, 4'd4, 0); send_data(16'h9999, 16);
    finish_write(1'b1, "R11 latch still set");
    exp_mem[4] = 16'h9999;
    read_check(4'd4, 1, "R11 later write", 0);

    // R9: write-all blocked unless cleared
    prot_clear = 1'b0;
    send_hdr(2'b00, 4'b0100, 0); send_data(16'hABCD, 16);
    finish_write(1'b0, "R9 blocked write-all");
    read_check(4'd14, 3, "R9 blocked unchanged", 0);
    prot_clear = 1'b1; prot_bound = 5'd16;
    send_hdr(2'b00, 4'b0100, 0); send_data(16'hABCD, 16);
    finish_write(1'b1, "R9 write-all");
    for (int i = 0; i < 16; i++) exp_mem[i] = 16'hABCD;
    read_check(4'd0, 16, "R9 write-all fill", 0);

    // R4 R5: disable, write fails, read works
    set_wen(1'b0);
    send_hdr(2'b01, 4'd5, 0); send_data(16'h5555, 16);
    finish_write(1'b0, "R4 after disable");
    read_check(4'd5, 1, "R4 R5 read while disabled", 0);

    finished = 1'b1;
    summary;
    $finish;
  end
endmodule